// File: doc/BRIEF.md
# Twin-Predicated Element Loop Sequencer

This block is the loop controller behind a vector-style issue stage that is built from scalar operations. A `start` pulse captures a vector length and two predicate masks. The block then issues one scalar element operation per clock cycle. Each issue carries a source element index and a destination element index. The source index only stops on elements whose source-mask bit is set, so the source array is read compressed. The destination index only stops on elements whose destination-mask bit is set, so the results are written expanded. The two indices advance independently of each other. The element datapath and the register file sit outside the block.

Three predication modes are supported. With no predication, every element from 0 up to VL-1 is used. In single mode one mask gates the source and the destination at the same index. In twin mode the two masks act separately. An optional data-dependent early exit lets the datapath report a test hit on the element just issued. The loop then stops at once, and the reported vector length becomes that element's destination index. The final length and a flag that shows whether the early exit fired are held on output registers after `done`.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset, `busy`, `issue_valid`, `done`, `ff_fired` are 0 and `vl_out` is 0.
- R2: While a loop runs, one issue is made per cycle. Consecutive issues have strictly increasing source and destination indices, and every issued index is below the captured VL.
- R3: Source indices never stop on an element whose effective source-mask bit is 0. Bit i of `src_mask` belongs to element i. The source index always moves to the lowest usable set bit at or above the current source position.
- R4: Destination indices never stop on an element whose effective destination-mask bit is 0. The destination index always moves to the lowest usable set bit at or above the current destination position.
- R5: In twin mode (`pred_mode` = 2'b10 or 2'b11), the source index and the destination index follow their own masks, so they may differ within one issue.
- R6: In single mode (`pred_mode` = 2'b01), `src_mask` gates both indices, `dst_mask` has no effect, and each issue has equal source and destination indices.
- R7: With no predication (`pred_mode` = 2'b00), both masks have no effect and the issues are (0,0), (1,1) ... (VL-1,VL-1).
- R8: When either index finds no usable set bit below VL, the loop ends without a further issue. `done` then pulses for one cycle, with `vl_out` equal to the captured VL and `ff_fired` = 0. A `vl_in` value above MAXVL acts as MAXVL.
- R9: With `ff_en` = 1, a `test_hit` in a cycle that has `issue_valid` ends the loop at that edge. No further issue follows. `done` pulses in the next cycle with `vl_out` equal to that issue's destination index and `ff_fired` = 1.
- R10: With `ff_en` = 0, `test_hit` has no effect on the issue sequence or on the outputs.
- R11: A `start` with `vl_in` = 0 raises `done` in the cycle right after the start edge, with `vl_out` = 0 and no issue.
- R12: A `start` pulse while `busy` is 1 is ignored, and the running loop completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a loop; sampled only while idle |
| vl_in | input | VLW (5) | Requested vector length |
| src_mask | input | MAXVL (16) | Source predicate, bit i for element i |
| dst_mask | input | MAXVL (16) | Destination predicate, bit i for element i |
| pred_mode | input | 2 | 00 none, 01 single, 10/11 twin |
| ff_en | input | 1 | Enable data-dependent early exit |
| test_hit | input | 1 | Test result for the element issued this cycle |
| busy | output | 1 | Loop in progress |
| issue_valid | output | 1 | An element operation is issued this cycle |
| issue_src_idx | output | IW (4) | Source element index of the issue |
| issue_dst_idx | output | IW (4) | Destination element index of the issue |
| done | output | 1 | One-cycle pulse at loop end |
| vl_out | output | VLW (5) | Final (possibly truncated) vector length |
| ff_fired | output | 1 | The last loop ended on a test hit |

## Verification
A wrong pointer or a wrong captured mask shows at the ports in the very cycle of the next issue: an index lands on a cleared mask bit, repeats, or moves backwards, and the scoreboard's pair comparison catches it at once. A fault in the end-of-loop logic shows one cycle after the last issue. It appears as a missing or extra issue, a `done` pulse in the wrong cycle, or a wrong `vl_out` or `ff_fired`. The empty-queue check at `done` exposes it. Mode decoding faults show as source/destination pairs that diverge where they must match, or match where they must diverge.

// File: rtl/tps_pkg.sv
// Shared types for the twin-predicated element sequencer.
// Assumes a 2-bit mode field; both upper codes select twin predication.
package tps_pkg;
    typedef enum logic [1:0] {
        PM_NONE   = 2'b00,
        PM_SINGLE = 2'b01,
        PM_TWIN   = 2'b10,
        PM_TWIN2  = 2'b11
    } pmode_e;
endpackage

// File: rtl/tps_window.sv
// Usable-element window: keeps mask bits at or above the current position
// and below the vector length. Assumes ptr and vl never exceed MAXVL.
module tps_window #(
    parameter int MAXVL = 16,
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic [MAXVL-1:0] mask,
    input  logic [VLW-1:0]   ptr,
    input  logic [VLW-1:0]   vl,
    output logic [MAXVL-1:0] win
);
    for (genvar i = 0; i < MAXVL; i++) begin : g_bit
        localparam logic [VLW-1:0] IV = VLW'(i);
        // gate one element by position range
        assign win[i] = mask[i] && (IV >= ptr) && (IV < vl);
    end
endmodule

// File: rtl/tps_finder.sv
// Lowest-set-bit finder over the usable window.
// Assumes IW bits are enough to index MAXVL elements.
module tps_finder #(
    parameter int MAXVL = 16,
    parameter int IW    = $clog2(MAXVL)
) (
    input  logic [MAXVL-1:0] vec,
    output logic             found,
    output logic [IW-1:0]    idx
);
    // priority encode toward bit 0
    always_comb begin
        idx = '0;
        for (int i = MAXVL - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign found = |vec;
endmodule

// File: rtl/twin_pred_seq.sv
// Twin-predicated element sequencer. It steps source and destination indices
// through separate masks, issues one element per cycle, and can stop early on
// a datapath test hit. Assumes test_hit is valid in the cycle of issue_valid.
module twin_pred_seq
    import tps_pkg::*;
#(
    parameter int MAXVL = 16,
    parameter int VLW   = $clog2(MAXVL + 1),
    parameter int IW    = $clog2(MAXVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl_in,
    input  logic [MAXVL-1:0] src_mask,
    input  logic [MAXVL-1:0] dst_mask,
    input  logic [1:0]       pred_mode,
    input  logic             ff_en,
    input  logic             test_hit,
    output logic             busy,
    output logic             issue_valid,
    output logic [IW-1:0]    issue_src_idx,
    output logic [IW-1:0]    issue_dst_idx,
    output logic             done,
    output logic [VLW-1:0]   vl_out,
    output logic             ff_fired
);
    localparam logic [VLW-1:0] VL_MAX = VLW'(MAXVL);

    logic             busy_q;
    logic [VLW-1:0]   vl_q;
    logic [MAXVL-1:0] smask_q, dmask_q;
    pmode_e           mode_q;
    logic             ff_q;
    logic [VLW-1:0]   sptr_q, dptr_q;
    logic             done_q, ff_fired_q;
    logic [VLW-1:0]   vl_out_q;

    pmode_e           mode_in;
    logic [VLW-1:0]   vl_clamp;
    logic [MAXVL-1:0] eff_smask, eff_dmask;
    logic [MAXVL-1:0] swin, dwin;
    logic             s_found, d_found;
    logic [IW-1:0]    s_idx, d_idx;

    assign mode_in  = pmode_e'(pred_mode);
    assign vl_clamp = (vl_in > VL_MAX) ? VL_MAX : vl_in;

    // resolve the effective masks for the selected predication mode
    always_comb begin
        case (mode_in)
            PM_NONE: begin
                eff_smask = '1;
                eff_dmask = '1;
            end
            PM_SINGLE: begin
                eff_smask = src_mask;
                eff_dmask = src_mask;
            end
            default: begin
                eff_smask = src_mask;
                eff_dmask = dst_mask;
            end
        endcase
    end

    tps_window #(.MAXVL(MAXVL), .VLW(VLW)) u_swin (
        .mask(smask_q), .ptr(sptr_q), .vl(vl_q), .win(swin)
    );
    tps_window #(.MAXVL(MAXVL), .VLW(VLW)) u_dwin (
        .mask(dmask_q), .ptr(dptr_q), .vl(vl_q), .win(dwin)
    );
    tps_finder #(.MAXVL(MAXVL), .IW(IW)) u_sfind (
        .vec(swin), .found(s_found), .idx(s_idx)
    );
    tps_finder #(.MAXVL(MAXVL), .IW(IW)) u_dfind (
        .vec(dwin), .found(d_found), .idx(d_idx)
    );

    assign issue_valid   = busy_q && s_found && d_found;
    assign issue_src_idx = s_idx;
    assign issue_dst_idx = d_idx;
    assign busy          = busy_q;
    assign done          = done_q;
    assign vl_out        = vl_out_q;
    assign ff_fired      = ff_fired_q;

    // loop control: capture, advance, and finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            vl_q       <= '0;
            smask_q    <= '0;
            dmask_q    <= '0;
            mode_q     <= PM_NONE;
            ff_q       <= 1'b0;
            sptr_q     <= '0;
            dptr_q     <= '0;
            done_q     <= 1'b0;
            vl_out_q   <= '0;
            ff_fired_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    if (vl_clamp == '0) begin
                        done_q     <= 1'b1;
                        vl_out_q   <= '0;
                        ff_fired_q <= 1'b0;
                    end else begin
                        busy_q  <= 1'b1;
                        vl_q    <= vl_clamp;
                        smask_q <= eff_smask;
                        dmask_q <= eff_dmask;
                        mode_q  <= mode_in;
                        ff_q    <= ff_en;
                        sptr_q  <= '0;
                        dptr_q  <= '0;
                    end
                end
            end else if (issue_valid) begin
                if (ff_q && test_hit) begin
                    busy_q     <= 1'b0;
                    done_q     <= 1'b1;
                    vl_out_q   <= VLW'(d_idx);
                    ff_fired_q <= 1'b1;
                end else begin
                    sptr_q <= VLW'(s_idx) + VLW'(1);
                    dptr_q <= VLW'(d_idx) + VLW'(1);
                end
            end else begin
                busy_q     <= 1'b0;
                done_q     <= 1'b1;
                vl_out_q   <= vl_q;
                ff_fired_q <= 1'b0;
            end
        end
    end
endmodule

// Protocol checker for the sequencer; attached below by bind.
module tps_checker
    import tps_pkg::*;
#(
    parameter int MAXVL = 16,
    parameter int VLW   = $clog2(MAXVL + 1),
    parameter int IW    = $clog2(MAXVL)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VLW-1:0]   vl_in,
    input logic             test_hit,
    input logic             busy,
    input logic             issue_valid,
    input logic [IW-1:0]    issue_src_idx,
    input logic [IW-1:0]    issue_dst_idx,
    input logic             done,
    input logic [MAXVL-1:0] smask_q,
    input logic [MAXVL-1:0] dmask_q,
    input logic [VLW-1:0]   vl_q,
    input pmode_e           mode_q,
    input logic             ff_q
);
    // R2
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && $past(issue_valid) |->
            (issue_src_idx > $past(issue_src_idx)) && (issue_dst_idx > $past(issue_dst_idx)));
    // R2
    below_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (VLW'(issue_src_idx) < vl_q) && (VLW'(issue_dst_idx) < vl_q));
    // R3
    src_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> smask_q[issue_src_idx]);
    // R4
    dst_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> dmask_q[issue_dst_idx]);
    // R6
    single_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && (mode_q == PM_SINGLE) |-> issue_src_idx == issue_dst_idx);
    // R9
    ff_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && ff_q && test_hit |=> done && !issue_valid && !busy);
    // R11
    zero_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (vl_in == '0) |=> done && !busy);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !issue_valid);
endmodule

bind twin_pred_seq tps_checker #(.MAXVL(MAXVL), .VLW(VLW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .test_hit(test_hit),
    .busy(busy), .issue_valid(issue_valid), .issue_src_idx(issue_src_idx),
    .issue_dst_idx(issue_dst_idx), .done(done), .smask_q(smask_q),
    .dmask_q(dmask_q), .vl_q(vl_q), .mode_q(mode_q), .ff_q(ff_q)
);

// File: tb/twin_pred_seq_bench.sv
// Scoreboard bench: the driver models the expected issue pairs and the final
// length; the monitor pops and compares them at each falling edge.
module twin_pred_seq_bench;
    localparam int MAXVL = 16;
    localparam int VLW   = 5;
    localparam int IW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [VLW-1:0]   vl_in = '0;
    logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
    logic [1:0]       pred_mode = 2'b00;
    logic             ff_en = 1'b0;
    logic             test_hit;
    logic             busy, issue_valid, done, ff_fired;
    logic [IW-1:0]    issue_src_idx, issue_dst_idx;
    logic [VLW-1:0]   vl_out;

    logic             hit_en = 1'b0;
    logic [IW-1:0]    hit_idx = '0;
    logic [2*IW-1:0]  exp_q[$];
    int               exp_vl = 0;
    logic             exp_ff = 1'b0;
    string            cur_req = "R1";
    int               checks = 0, errors = 0;
    logic             mon_on = 1'b0;

    always #5 clk = ~clk;

    assign test_hit = hit_en && issue_valid && (issue_dst_idx == hit_idx);

    twin_pred_seq #(.MAXVL(MAXVL)) u_twin_pred_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .src_mask(src_mask), .dst_mask(dst_mask), .pred_mode(pred_mode),
        .ff_en(ff_en), .test_hit(test_hit), .busy(busy),
        .issue_valid(issue_valid), .issue_src_idx(issue_src_idx),
        .issue_dst_idx(issue_dst_idx), .done(done), .vl_out(vl_out),
        .ff_fired(ff_fired)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: compare issues and loop results against the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (issue_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, "unexpected issue src", int'(issue_src_idx), -1);
                end else begin
                    logic [2*IW-1:0] e;
                    e = exp_q.pop_front();
                    check(issue_src_idx == e[2*IW-1:IW], cur_req, "src idx",
                          int'(issue_src_idx), int'(e[2*IW-1:IW]));
                    check(issue_dst_idx == e[IW-1:0], cur_req, "dst idx",
                          int'(issue_dst_idx), int'(e[IW-1:0]));
                end
            end
            if (done) begin
                check(int'(vl_out) == exp_vl, cur_req, "vl_out", int'(vl_out), exp_vl);
                check(ff_fired == exp_ff, cur_req, "ff_fired", int'(ff_fired), int'(exp_ff));
                check(exp_q.size() == 0, cur_req, "missing issues", exp_q.size(), 0);
            end
        end
    end

    // driver: model the loop, queue expectations, pulse start, wait for done
    task automatic run(input string req, input logic [1:0] mode, input int vl,
                       input logic [MAXVL-1:0] sm, input logic [MAXVL-1:0] dm,
                       input bit ff, input bit hen, input int hidx, input bit poke);
        logic [MAXVL-1:0] es, ed;
        int vlc, s, d, fs, fd;
        bit stop;
        cur_req = req;
        vlc = (vl > MAXVL) ? MAXVL : vl;
        case (mode)
            2'b00:   begin es = '1; ed = '1; end
            2'b01:   begin es = sm; ed = sm; end
            default: begin es = sm; ed = dm; end
        endcase
        exp_q.delete();
        exp_vl = vlc;
        exp_ff = 1'b0;
        s = 0; d = 0; stop = 1'b0;
        while (!stop) begin
            fs = -1; fd = -1;
            for (int i = vlc - 1; i >= s; i--) if (es[i]) fs = i;
            for (int i = vlc - 1; i >= d; i--) if (ed[i]) fd = i;
            if (fs < 0 || fd < 0) begin
                stop = 1'b1;
            end else begin
                exp_q.push_back({IW'(fs), IW'(fd)});
                if (ff && hen && fd == hidx) begin
                    exp_vl = fd;
                    exp_ff = 1'b1;
                    stop = 1'b1;
                end
                s = fs + 1;
                d = fd + 1;
            end
        end
        hit_en    = hen;
        hit_idx   = IW'(hidx);
        pred_mode = mode;
        vl_in     = VLW'(vl);
        src_mask  = sm;
        dst_mask  = dm;
        ff_en     = ff;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (vlc == 0) begin
            check(done == 1'b1, "R11", "done after zero-length start", int'(done), 1);
            check(issue_valid == 1'b0, "R11", "issue on zero length", int'(issue_valid), 0);
        end
        if (poke) begin
            // R12: retrigger with other settings mid-loop
            start     = 1'b1;
            vl_in     = VLW'(2);
            pred_mode = 2'b00;
            ff_en     = 1'b1;
            src_mask  = '0;
            dst_mask  = '0;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, req, "busy after done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy", int'(busy), 0);
        check(issue_valid == 1'b0, "R1", "issue_valid", int'(issue_valid), 0);
        check(done == 1'b0, "R1", "done", int'(done), 0);
        check(ff_fired == 1'b0, "R1", "ff_fired", int'(ff_fired), 0);
        check(vl_out == '0, "R1", "vl_out", int'(vl_out), 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        // R7: no predication, masks ignored
        run("R7", 2'b00, 5, 16'h0000, 16'h0000, 1'b0, 1'b0, 0, 1'b0);
        // R5 R3 R4: twin compress/expand
        run("R5", 2'b10, 8, 16'b1010_0110, 16'b0011_1100, 1'b0, 1'b0, 0, 1'b0);
        // R6: single mode, dst_mask noise ignored
        run("R6", 2'b01, 12, 16'b1001_0010_1101, 16'hF0F0, 1'b0, 1'b0, 0, 1'b0);
        // R3: dense destination, sparse source, code 2'b11 is twin
        run("R3", 2'b11, 16, 16'h8421, 16'hFFFF, 1'b0, 1'b0, 0, 1'b0);
        // R4: destination runs out first
        run("R4", 2'b10, 10, 16'h03FF, 16'h0208, 1'b0, 1'b0, 0, 1'b0);
        // R9: early exit in twin mode at destination 9
        run("R9", 2'b10, 16, 16'hAAAA, 16'h0F30, 1'b1, 1'b1, 9, 1'b0);
        // R9: early exit on the first element
        run("R9", 2'b00, 7, 16'h0000, 16'h0000, 1'b1, 1'b1, 0, 1'b0);
        // R10: test hits ignored with fail-first off
        run("R10", 2'b00, 6, 16'h0000, 16'h0000, 1'b0, 1'b1, 2, 1'b0);
        // R11: zero length
        run("R11", 2'b10, 0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 0, 1'b0);
        // R8: over-long VL clamps to MAXVL
        run("R8", 2'b00, 31, 16'h0000, 16'h0000, 1'b0, 1'b0, 0, 1'b0);
        // R8: empty source mask ends with no issue
        run("R8", 2'b10, 9, 16'h0000, 16'h01FF, 1'b0, 1'b0, 0, 1'b0);
        // R12: start during busy ignored
        run("R12", 2'b10, 11, 16'h07F5, 16'h06DB, 1'b0, 1'b0, 0, 1'b1);
        // R2: full-length run after the others
        run("R2", 2'b01, 16, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog %s actual=timeout expected=done", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule